// File: doc/BRIEF.md
# Receive Field FIFO with Length Header

This block holds fields captured from a serial bus until software collects them. Whenever the receive shift register completes a field, it presents the field's bit length, its type (address or data) and up to 32 bits of payload together with a one-cycle push strobe. The block stores them as one entry of an eight-deep circular buffer. Entries leave in arrival order.

Each entry is read in two steps through two read strobes. A header read returns the length and type of the oldest entry and arms it. A data read then returns the payload and removes the entry. A data read that is not preceded by a header read is refused and recorded in a sticky order-error flag.

When all eight entries are occupied the buffer freezes. New fields are discarded while the shift register upstream carries on, and a sticky overflow flag records the loss. A store-own input chooses whether fields this node transmitted itself are kept, which suits single-master systems. A flush input empties the buffer in one cycle. Count, full and empty status are always visible.

Top module: `rxfield_fifo`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, full_o, overflow_o and order_err_o are 0, and all read outputs are 0.
- R2: Accepted fields are kept in arrival order. One cycle after hdr_rd_i, hdr_len_o and hdr_kind_o show the length and type of the oldest entry. hdr_kind_o is 0 for an address field and 1 for a data field.
- R3: A data_rd_i that follows a header read of the same entry puts that entry's payload on data_o one cycle later and removes the entry, so count_o drops by one.
- R4: A data_rd_i with no prior header read of the head entry sets data_o to 0 and removes nothing. This includes an empty buffer and a data read in the same cycle as hdr_rd_i. It also sets order_err_o, which stays at 1 until status_clr_i.
- R5: Repeated header reads without a data read return the same header and leave count_o unchanged.
- R6: While eight entries are held, a push is discarded and the stored entries stay unchanged. overflow_o becomes 1 and stays at 1 until status_clr_i. If a set and a clear fall in the same cycle, the set wins.
- R7: A push with push_own_i=1 is discarded without setting overflow_o when store_own_i=0, and is stored normally when store_own_i=1.
- R8: flush_i makes count_o 0 on the next cycle and cancels any pending header read. A push or read in the same cycle as the flush has no effect.
- R9: A header read on an empty buffer returns length 0 and type 0 and arms nothing.
- R10: count_o always equals the number of held entries. full_o is 1 exactly at 8 entries and empty_o is 1 exactly at 0. A push and a valid data read in the same cycle keep the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Field complete strobe from the shift register |
| push_len_i | input | 6 | Field length in bits |
| push_kind_i | input | 1 | Field type: 0 address, 1 data |
| push_bits_i | input | 32 | Field payload |
| push_own_i | input | 1 | Field was transmitted by this node |
| store_own_i | input | 1 | 1 keeps own fields, 0 discards them |
| hdr_rd_i | input | 1 | Header read strobe |
| data_rd_i | input | 1 | Data read strobe |
| flush_i | input | 1 | Empty the buffer |
| status_clr_i | input | 1 | Clear overflow and order-error flags |
| hdr_len_o | output | 6 | Length from the last header read |
| hdr_kind_o | output | 1 | Type from the last header read |
| data_o | output | 32 | Payload from the last data read |
| count_o | output | 4 | Number of held entries |
| full_o | output | 1 | Buffer holds 8 entries |
| empty_o | output | 1 | Buffer holds no entries |
| overflow_o | output | 1 | Sticky: a field was lost to a full buffer |
| order_err_o | output | 1 | Sticky: data read without its header read |

## Verification
The bench fills the buffer to exactly eight entries and pushes once more. A design that overwrote the oldest entry or wrapped its pointer early would return a wrong payload when the buffer is drained. It issues data reads with no header read, on an empty buffer and in the same cycle as a header read. A design that popped in any of these cases would lose an entry and show a short count. It flushes between a header read and its data read, so a design that kept the armed state would hand out stale data instead of flagging an order error. It also pushes own fields under both settings of store_own_i. A design that treated a suppressed field as a drop would raise overflow_o.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int unsigned FIFO_DEPTH = 8;
    localparam int unsigned LEN_W      = 6;
    localparam int unsigned BITS_W     = 32;
    localparam int unsigned PTR_W      = $clog2(FIFO_DEPTH);
    localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);

    typedef enum logic {
        KIND_ADDR = 1'b0,
        KIND_DATA = 1'b1
    } field_kind_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        field_kind_e       kind;
        logic [BITS_W-1:0] bits;
    } field_t;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(FIFO_DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  field_t           wr_field,
    input  logic             pop,
    input  logic             flush,
    output field_t           head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    field_t           mem [FIFO_DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign full  = (count == CNT_W'(FIFO_DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_field;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_next(wr_ptr);
            if (pop)   rd_ptr <= ptr_next(rd_ptr);
            case ({wr_en, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(FIFO_DEPTH));

    // R6
    no_write_full_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R10
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));
endmodule

// File: rtl/rxf_admit.sv
module rxf_admit
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_own,
    input  logic store_own,
    input  logic full,
    input  logic flush,
    input  logic clr,
    output logic wr_en,
    output logic overflow
);
    logic wanted, drop;

    assign wanted = push && !flush && (!push_own || store_own);
    assign wr_en  = wanted && !full;
    assign drop   = wanted && full;

    always_ff @(posedge clk) begin
        if (rst)       overflow <= 1'b0;
        else if (drop) overflow <= 1'b1;
        else if (clr)  overflow <= 1'b0;
    end

    // R6
    drop_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush && (!push_own || store_own)) |=> overflow);

    // R7
    own_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (push && push_own && !store_own && !overflow && !full) |=> !overflow);
endmodule

// File: rtl/rxf_reader.sv
module rxf_reader
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_rd,
    input  logic              data_rd,
    input  logic              flush,
    input  logic              clr,
    input  logic              empty,
    input  field_t            head,
    output logic              pop,
    output logic [LEN_W-1:0]  hdr_len,
    output field_kind_e       hdr_kind,
    output logic [BITS_W-1:0] data,
    output logic              order_err
);
    logic armed;
    logic bad_read;

    assign pop      = data_rd && !hdr_rd && armed && !flush;
    assign bad_read = data_rd && !flush && !pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            hdr_len   <= '0;
            hdr_kind  <= KIND_ADDR;
            data      <= '0;
            order_err <= 1'b0;
        end else begin
            if (flush) begin
                armed <= 1'b0;
            end else begin
                if (hdr_rd) begin
                    if (empty) begin
                        hdr_len  <= '0;
                        hdr_kind <= KIND_ADDR;
                        armed    <= 1'b0;
                    end else begin
                        hdr_len  <= head.len;
                        hdr_kind <= head.kind;
                        armed    <= 1'b1;
                    end
                end
                if (pop) begin
                    data  <= head.bits;
                    armed <= 1'b0;
                end else if (data_rd) begin
                    data  <= '0;
                end
            end
            if (bad_read)  order_err <= 1'b1;
            else if (clr)  order_err <= 1'b0;
        end
    end

    // R4
    order_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !armed && !flush) |=> (order_err && data == '0));

    // R3
    armed_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> !empty);
endmodule

// File: rtl/rxfield_fifo.sv
module rxfield_fifo
    import rxf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push_i,
    input  logic [LEN_W-1:0]      push_len_i,
    input  logic                  push_kind_i,
    input  logic [BITS_W-1:0]     push_bits_i,
    input  logic                  push_own_i,
    input  logic                  store_own_i,
    input  logic                  hdr_rd_i,
    input  logic                  data_rd_i,
    input  logic                  flush_i,
    input  logic                  status_clr_i,
    output logic [LEN_W-1:0]      hdr_len_o,
    output logic                  hdr_kind_o,
    output logic [BITS_W-1:0]     data_o,
    output logic [CNT_W-1:0]      count_o,
    output logic                  full_o,
    output logic                  empty_o,
    output logic                  overflow_o,
    output logic                  order_err_o
);
    field_t      in_field, head;
    logic        wr_en, pop;
    field_kind_e kind_q;

    assign in_field.len  = push_len_i;
    assign in_field.kind = field_kind_e'(push_kind_i);
    assign in_field.bits = push_bits_i;

    rxf_admit u_admit (
        .clk(clk), .rst(rst), .push(push_i), .push_own(push_own_i),
        .store_own(store_own_i), .full(full_o), .flush(flush_i),
        .clr(status_clr_i), .wr_en(wr_en), .overflow(overflow_o)
    );

    rxf_store u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_field(in_field),
        .pop(pop), .flush(flush_i), .head(head), .count(count_o),
        .full(full_o), .empty(empty_o)
    );

    rxf_reader u_reader (
        .clk(clk), .rst(rst), .hdr_rd(hdr_rd_i), .data_rd(data_rd_i),
        .flush(flush_i), .clr(status_clr_i), .empty(empty_o), .head(head),
        .pop(pop), .hdr_len(hdr_len_o), .hdr_kind(kind_q), .data(data_o),
        .order_err(order_err_o)
    );

    assign hdr_kind_o = kind_q;

    // R10
    flags_match_chk: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));
endmodule

// File: tb/rxfield_fifo_tb.sv
module rxfield_fifo_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        push_i, push_kind_i, push_own_i, store_own_i;
    logic [5:0]  push_len_i;
    logic [31:0] push_bits_i;
    logic        hdr_rd_i, data_rd_i, flush_i, status_clr_i;
    logic [5:0]  hdr_len_o;
    logic        hdr_kind_o;
    logic [31:0] data_o;
    logic [3:0]  count_o;
    logic        full_o, empty_o, overflow_o, order_err_o;

    int checks = 0;
    int failures = 0;
    logic [38:0] sb[$];

    always #2.5 clk = ~clk;

    rxfield_fifo u_dut (.*);

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic idle();
        push_i = 0; hdr_rd_i = 0; data_rd_i = 0; flush_i = 0; status_clr_i = 0;
    endtask

    // driver: one push per cycle, model updated from the requirements
    task automatic push_field(input logic [5:0] len, input logic kind, input logic [31:0] bits, input logic own);
        @(negedge clk);
        push_i = 1; push_len_i = len; push_kind_i = kind; push_bits_i = bits; push_own_i = own;
        if ((!own || store_own_i) && sb.size() < 8) sb.push_back({len, kind, bits});
        @(negedge clk);
        push_i = 0; push_own_i = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); status_clr_i = 1;
        @(negedge clk); status_clr_i = 0;
    endtask

    // monitor: reads the head entry and compares it with the scoreboard
    task automatic read_field();
        logic [38:0] e;
        e = sb.pop_front();
        @(negedge clk); hdr_rd_i = 1;
        @(negedge clk); hdr_rd_i = 0;
        chk_eq("R2 header length", hdr_len_o, e[38:33]);
        chk_eq("R2 header kind", hdr_kind_o, e[32]);
        data_rd_i = 1;
        @(negedge clk); data_rd_i = 0;
        chk_eq("R3 payload", data_o, e[31:0]);
        chk_eq("R3 count after pop", count_o, sb.size());
    endtask

    initial begin
        #(5.0 * 20000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        push_len_i = 0; push_kind_i = 0; push_bits_i = 0; push_own_i = 0; store_own_i = 1;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 count", count_o, 0);
        chk_eq("R1 empty", empty_o, 1);
        chk_eq("R1 full", full_o, 0);
        chk_eq("R1 overflow", overflow_o, 0);
        chk_eq("R1 order_err", order_err_o, 0);
        chk_eq("R1 data", data_o, 0);
        chk_eq("R1 hdr", {hdr_len_o, hdr_kind_o}, 0);

        // R2 R3 R10 basic order
        push_field(6'd8, 1'b0, 32'h0000_00A5, 0);
        push_field(6'd32, 1'b1, 32'hDEAD_BEEF, 0);
        push_field(6'd13, 1'b1, 32'h0000_1ABC, 0);
        chk_eq("R10 count three", count_o, 3);
        chk_eq("R10 not empty", empty_o, 0);
        read_field(); read_field(); read_field();
        chk_eq("R10 empty again", empty_o, 1);

        // R4 data read on empty buffer
        @(negedge clk); data_rd_i = 1;
        @(negedge clk); data_rd_i = 0;
        chk_eq("R4 empty data zero", data_o, 0);
        chk_eq("R4 order_err set", order_err_o, 1);
        // R4 data read without header on non-empty buffer
        push_field(6'd16, 1'b1, 32'h0000_CAFE, 0);
        pulse_clr();
        chk_eq("R4 order_err cleared", order_err_o, 0);
        @(negedge clk); data_rd_i = 1;
        @(negedge clk); data_rd_i = 0;
        chk_eq("R4 no-header data zero", data_o, 0);
        chk_eq("R4 no pop", count_o, 1);
        chk_eq("R4 sticky set", order_err_o, 1);
        @(negedge clk);
        chk_eq("R4 sticky holds", order_err_o, 1);
        // R4 same-cycle header and data read
        @(negedge clk); hdr_rd_i = 1; data_rd_i = 1;
        @(negedge clk); hdr_rd_i = 0; data_rd_i = 0;
        chk_eq("R4 same-cycle no pop", count_o, 1);
        chk_eq("R4 same-cycle data zero", data_o, 0);
        pulse_clr();
        // R5 repeated header read
        @(negedge clk); hdr_rd_i = 1;
        @(negedge clk); hdr_rd_i = 1;
        @(negedge clk); hdr_rd_i = 0;
        chk_eq("R5 header repeat", hdr_len_o, 16);
        chk_eq("R5 no pop", count_o, 1);
        read_field();

        // R9 header read on empty buffer
        @(negedge clk); hdr_rd_i = 1;
        @(negedge clk); hdr_rd_i = 0;
        chk_eq("R9 empty header zero", {hdr_len_o, hdr_kind_o}, 0);
        @(negedge clk); data_rd_i = 1;
        @(negedge clk); data_rd_i = 0;
        chk_eq("R9 nothing armed", order_err_o, 1);
        pulse_clr();

        // R6 fill and overflow
        for (int i = 0; i < 8; i++) push_field(6'(i + 1), i[0], 32'h1000_0000 + i, 0);
        chk_eq("R10 full at eight", full_o, 1);
        chk_eq("R6 no overflow yet", overflow_o, 0);
        push_field(6'd63, 1'b1, 32'hBAD0_BAD0, 0);
        chk_eq("R6 overflow set", overflow_o, 1);
        chk_eq("R6 count frozen", count_o, 8);
        // R6 set wins over clear
        @(negedge clk); push_i = 1; status_clr_i = 1;
        @(negedge clk); push_i = 0; status_clr_i = 0;
        chk_eq("R6 set beats clear", overflow_o, 1);
        for (int i = 0; i < 8; i++) read_field();
        chk_eq("R6 overflow sticky", overflow_o, 1);
        pulse_clr();
        chk_eq("R6 overflow cleared", overflow_o, 0);

        // R7 own-field suppression
        store_own_i = 0;
        push_field(6'd9, 1'b0, 32'h0000_0111, 1);
        chk_eq("R7 own dropped", count_o, 0);
        chk_eq("R7 no overflow", overflow_o, 0);
        store_own_i = 1;
        push_field(6'd10, 1'b1, 32'h0000_0222, 1);
        chk_eq("R7 own stored", count_o, 1);
        read_field();

        // R10 push and pop in the same cycle
        push_field(6'd4, 1'b0, 32'h0000_0004, 0);
        @(negedge clk); hdr_rd_i = 1;
        @(negedge clk); hdr_rd_i = 0; data_rd_i = 1;
        push_i = 1; push_len_i = 6'd5; push_kind_i = 1; push_bits_i = 32'h0000_0005;
        @(negedge clk); data_rd_i = 0; push_i = 0;
        chk_eq("R10 simultaneous payload", data_o, 32'h4);
        chk_eq("R10 simultaneous count", count_o, 1);
        void'(sb.pop_front());
        sb.push_back({6'd5, 1'b1, 32'h5});
        read_field();

        // R8 flush cancels pending header
        push_field(6'd7, 1'b0, 32'h77, 0);
        push_field(6'd8, 1'b0, 32'h88, 0);
        @(negedge clk); hdr_rd_i = 1;
        @(negedge clk); hdr_rd_i = 0; flush_i = 1; push_i = 1;
        @(negedge clk); flush_i = 0; push_i = 0;
        sb.delete();
        chk_eq("R8 flushed count", count_o, 0);
        chk_eq("R8 flushed empty", empty_o, 1);
        @(negedge clk); data_rd_i = 1;
        @(negedge clk); data_rd_i = 0;
        chk_eq("R8 header cancelled", order_err_o, 1);
        chk_eq("R8 data zero", data_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule